// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial-flash transaction at a time over a four-wire SPI link. It is driven by three registers. Software first loads an address register and a data register. It then writes a control word that holds an opcode, a frame-shape code, a chip-select hold flag and a start bit. The engine sends the opcode, then any address bytes, then any dummy bytes, then any data bytes. Bytes that come back during the data phase are written into the data register. The start bit reads back as busy until the frame has finished.

The hold flag keeps chip select low after a frame. While chip select is held, each further start sends only the byte in the opcode field, so software can stream a long transfer one byte per command. A control write with both start and hold clear ends the held transaction.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Register select encoding is 0 = control, 1 = address, 2 = data. After reset, all three readbacks are zero, chip select is high and the serial clock is low. Control readback layout: opcode in bits 7:0, frame code in bits 10:8, hold flag in bit 12, busy in bit 31, all other bits zero.
- R2: An idle control write with bit 31 set starts a frame. Bit 31 of the control readback reads 1 on the cycle after that write and returns to 0 when the frame has ended.
- R3: The link runs in SPI mode 0 and sends each byte most significant bit first. The serial clock period is CLK_DIV system clocks. Chip select falls at least half a serial period before the first rising edge and rises no earlier than half a period after the last falling edge. While busy is low the serial clock stays low.
- R4: Frame shapes by code, always sent in the order opcode, address, dummy, data:
  - 0: opcode only.
  - 1: one data byte.
  - 2: three address bytes.
  - 3: three address bytes and one data byte.
  - 4: three address bytes and four data bytes.
  - 5: three address bytes, four dummy bytes and four data bytes.
  - 7: three address bytes, one dummy byte and four data bytes.
  - 6: treated as opcode only.
- R5: Address bytes come from address register bits 23:0 and are sent high byte first.
- R6: Data byte k of the frame (k = 0..3) is sent from data register bits 8k+7:8k. The byte received in its place replaces those same bits. One-byte frames use bits 7:0 and leave bits 31:8 unchanged.
- R7: Dummy bytes are sent as 0x00, and whatever the device returns during them does not reach the data register.
- R8: A frame started with the hold flag (bit 12) set ends with chip select still low and busy low.
- R9: A start issued while chip select is held sends only the opcode-field byte, whatever the frame code. Chip select then stays low only if this start also has the hold flag set.
- R10: An idle control write with start and hold both clear raises chip select and sends nothing.
- R11: Writes to any register while busy is high are ignored. The running frame and the register contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 control, 1 address, 2 data) |
| regWrData | input | 32 | Register write data |
| ctrlStatus | output | 32 | Control readback with busy in bit 31 |
| addrValue | output | 32 | Address register readback (bits 23:0 used) |
| dataValue | output | 32 | Data register readback |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
A slip in the phase sequencer shows up on the wire within the same frame. The device model sees the wrong byte count or a byte in the wrong place, and it sees this before busy falls. A wrong byte index in the capture path appears in the data register once the frame finishes, as a byte in the wrong lane or an overwritten dummy. A chip-select flag left in the wrong state is visible on the pin at the end of the frame. It also changes whether the next start sends one byte or a whole frame.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic       startLoad;
    logic       sampleIn;
    logic       shiftBit;
    logic       loadNext;
    logic       storeRx;
    phase_e     nextPh;
    logic [1:0] nextIdx;
    logic [1:0] curIdx;
  } dpStrobe_t;

  function automatic logic [2:0] addrCount(input logic [2:0] code);
    return (code == 3'd0 || code == 3'd1 || code == 3'd6) ? 3'd0 : 3'd3;
  endfunction

  function automatic logic [2:0] dummyCount(input logic [2:0] code);
    case (code)
      3'd5:    return 3'd4;
      3'd7:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] dataCount(input logic [2:0] code);
    case (code)
      3'd1, 3'd3:       return 3'd1;
      3'd4, 3'd5, 3'd7: return 3'd4;
      default:          return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrReq,
  input  logic       startBit,
  input  logic       holdBit,
  input  logic [2:0] codeBits,
  output dpStrobe_t  sb,
  output logic       busy,
  output logic       csN,
  output logic       sclk,
  output logic       holdQ,
  output logic [2:0] codeQ
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} state_e;

  state_e     state;
  logic [HCW-1:0] halfCnt;
  logic [2:0] bitCnt;
  phase_e     ph;
  logic [1:0] idx;
  logic       contQ, csHeld, csNQ, sclkQ;
  logic       halfTick, ctrlWr, startAcc, byteEnd, hasNext;
  phase_e     nPh;
  logic [1:0] nIdx;
  logic [2:0] nAddr, nDum, nDat;

  assign halfTick = (halfCnt == HCW'(HALF - 1));
  assign ctrlWr   = ctrlWrReq && (state == ST_IDLE);
  assign startAcc = ctrlWr && startBit;
  assign byteEnd  = (state == ST_SHIFT) && halfTick && sclkQ && (bitCnt == 3'd7);

  always_comb begin
    nAddr   = addrCount(codeQ);
    nDum    = dummyCount(codeQ);
    nDat    = dataCount(codeQ);
    hasNext = 1'b0;
    nPh     = PH_OP;
    nIdx    = 2'd0;
    unique case (ph)
      PH_OP: begin
        if (!contQ) begin
          if (nAddr != 3'd0) begin hasNext = 1'b1; nPh = PH_ADDR; end
          else if (nDum != 3'd0) begin hasNext = 1'b1; nPh = PH_DUMMY; end
          else if (nDat != 3'd0) begin hasNext = 1'b1; nPh = PH_DATA; end
        end
      end
      PH_ADDR: begin
        if ({1'b0, idx} < nAddr - 3'd1) begin hasNext = 1'b1; nPh = PH_ADDR; nIdx = idx + 2'd1; end
        else if (nDum != 3'd0) begin hasNext = 1'b1; nPh = PH_DUMMY; end
        else if (nDat != 3'd0) begin hasNext = 1'b1; nPh = PH_DATA; end
      end
      PH_DUMMY: begin
        if ({1'b0, idx} < nDum - 3'd1) begin hasNext = 1'b1; nPh = PH_DUMMY; nIdx = idx + 2'd1; end
        else if (nDat != 3'd0) begin hasNext = 1'b1; nPh = PH_DATA; end
      end
      PH_DATA: begin
        if ({1'b0, idx} < nDat - 3'd1) begin hasNext = 1'b1; nPh = PH_DATA; nIdx = idx + 2'd1; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; halfCnt <= '0; bitCnt <= '0; ph <= PH_OP; idx <= '0;
      codeQ <= '0; holdQ <= 1'b0; contQ <= 1'b0; csHeld <= 1'b0;
      csNQ <= 1'b1; sclkQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        codeQ <= codeBits;
        holdQ <= holdBit;
      end
      unique case (state)
        ST_IDLE: begin
          if (startAcc) begin
            state <= ST_SETUP; halfCnt <= '0; bitCnt <= '0;
            ph <= PH_OP; idx <= '0; contQ <= csHeld; csNQ <= 1'b0;
          end else if (ctrlWr && !holdBit) begin
            csNQ <= 1'b1; csHeld <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (halfTick) begin
            halfCnt <= '0; sclkQ <= 1'b1; state <= ST_SHIFT;
          end else halfCnt <= halfCnt + 1'b1;
        end
        ST_SHIFT: begin
          if (halfTick) begin
            halfCnt <= '0;
            if (!sclkQ) sclkQ <= 1'b1;
            else begin
              sclkQ <= 1'b0;
              if (bitCnt == 3'd7) begin
                bitCnt <= '0;
                if (hasNext) begin ph <= nPh; idx <= nIdx; end
                else state <= ST_HOLD;
              end else bitCnt <= bitCnt + 3'd1;
            end
          end else halfCnt <= halfCnt + 1'b1;
        end
        ST_HOLD: begin
          if (halfTick) begin
            halfCnt <= '0; state <= ST_IDLE;
            csNQ <= ~holdQ; csHeld <= holdQ;
          end else halfCnt <= halfCnt + 1'b1;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = csNQ;
  assign sclk = sclkQ;

  assign sb.startLoad = startAcc;
  assign sb.sampleIn  = halfTick && ((state == ST_SETUP) || (state == ST_SHIFT && !sclkQ));
  assign sb.shiftBit  = (state == ST_SHIFT) && halfTick && sclkQ && (bitCnt != 3'd7);
  assign sb.loadNext  = byteEnd && hasNext;
  assign sb.storeRx   = byteEnd && (ph == PH_DATA);
  assign sb.nextPh    = nPh;
  assign sb.nextIdx   = nIdx;
  assign sb.curIdx    = idx;

  assert_sclk_low_idle_R3: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !sclkQ);
  assert_cs_setup_R3: assert property (@(posedge clk) disable iff (!rstN) $rose(sclkQ) |-> $past(!csNQ));
  assert_cs_hold_R3: assert property (@(posedge clk) disable iff (!rstN) $rose(csNQ) |-> $past(!sclkQ));
  assert_held_cs_R8: assert property (@(posedge clk) disable iff (!rstN) ($fell(busy) && holdQ) |-> !csNQ);
endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWrData,
  input  logic        busy,
  input  dpStrobe_t   sb,
  input  logic        miso,
  output logic        mosi,
  output logic [7:0]  opValue,
  output logic [23:0] addrQ,
  output logic [31:0] dataQ
);
  logic [7:0] shiftQ, rxQ, nextByte;
  logic [4:0] addrShift;

  assign addrShift = 5'd16 - {sb.nextIdx, 3'b000};

  always_comb begin
    unique case (sb.nextPh)
      PH_ADDR:  nextByte = addrQ[addrShift +: 8];
      PH_DATA:  nextByte = dataQ[{sb.nextIdx, 3'b000} +: 8];
      PH_DUMMY: nextByte = 8'h00;
      PH_OP:    nextByte = opValue;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; dataQ <= '0; opValue <= '0; shiftQ <= '0; rxQ <= '0;
    end else begin
      if (regWrEn && !busy) begin
        if (regSel == SEL_ADDR) addrQ <= regWrData[23:0];
        if (regSel == SEL_DATA) dataQ <= regWrData;
        if (regSel == SEL_CTRL) opValue <= regWrData[7:0];
      end
      if (sb.startLoad)     shiftQ <= regWrData[7:0];
      else if (sb.loadNext) shiftQ <= nextByte;
      else if (sb.shiftBit) shiftQ <= {shiftQ[6:0], 1'b0};
      if (sb.sampleIn) rxQ <= {rxQ[6:0], miso};
      if (sb.storeRx)  dataQ[{sb.curIdx, 3'b000} +: 8] <= rxQ;
    end
  end

  assign mosi = shiftQ[7];

  assert_addr_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regSel == SEL_ADDR) |=> $stable(addrQ));
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfe_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] ctrlStatus,
  output logic [31:0] addrValue,
  output logic [31:0] dataValue,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso
);
  dpStrobe_t   sb;
  logic        busy, holdQ;
  logic [2:0]  codeQ;
  logic [7:0]  opValue;
  logic [23:0] addrQ;

  sfe_ctrl #(.CLK_DIV(CLK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctrlWrReq(regWrEn && regSel == SEL_CTRL),
    .startBit(regWrData[31]), .holdBit(regWrData[12]), .codeBits(regWrData[10:8]),
    .sb(sb), .busy(busy), .csN(spiCsN), .sclk(spiSclk), .holdQ(holdQ), .codeQ(codeQ)
  );

  sfe_datapath dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .busy(busy), .sb(sb), .miso(spiMiso), .mosi(spiMosi),
    .opValue(opValue), .addrQ(addrQ), .dataQ(dataValue)
  );

  assign ctrlStatus = {busy, 18'b0, holdQ, 1'b0, codeQ, opValue};
  assign addrValue  = {8'b0, addrQ};

  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rstN) spiSclk |-> $stable(spiMosi));
endmodule

// File: tb/sflash_cmd_engine_tb.sv
`timescale 1ns/1ps
module sflash_cmd_engine_tb_top;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [1:0] regSel = 2'd3;
  logic [31:0] regWrData = '0;
  logic [31:0] ctrlStatus, addrValue, dataValue;
  logic spiSclk, spiCsN, spiMosi, spiMiso;

  int checks = 0, fails = 0, cycles = 0;

  sflash_cmd_engine #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .ctrlStatus(ctrlStatus), .addrValue(addrValue), .dataValue(dataValue),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  always #2 clk = ~clk;

  // device model
  logic [7:0] txLog [0:31];
  logic [7:0] resp  [0:31];
  logic [7:0] slvShift = '0;
  int txCount = 0, slvBitIn = 0, respByte = 0, respBit = 0;
  time lastRise = 0, lastPeriod = 0;

  assign spiMiso = (respByte < 32) ? resp[respByte][7 - respBit] : 1'b0;

  always @(posedge spiSclk) if (!spiCsN) begin
    slvShift = {slvShift[6:0], spiMosi};
    slvBitIn++;
    if (slvBitIn == 8) begin txLog[txCount] = slvShift; txCount++; slvBitIn = 0; end
    if (lastRise != 0) lastPeriod = $time - lastRise;
    lastRise = $time;
  end

  always @(negedge spiSclk) if (!spiCsN) begin
    respBit++;
    if (respBit == 8) begin respBit = 0; respByte++; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearSlave();
    txCount = 0; slvBitIn = 0; respByte = 0; respBit = 0; lastRise = 0;
    for (int i = 0; i < 32; i++) resp[i] = 8'h00;
  endtask

  function automatic logic [31:0] mkCtrl(input bit start, input bit hold, input logic [2:0] code, input logic [7:0] op);
    return {start, 18'b0, hold, 1'b0, code, op};
  endfunction

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regSel = 2'd3;
  endtask

  task automatic waitIdle();
    while (ctrlStatus[31]) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [31:0] word);
    writeReg(2'd0, word);
    check(ctrlStatus[31] == 1'b1, "R2 busy after start", {31'b0, ctrlStatus[31]}, 32'd1);
    waitIdle();
    check(ctrlStatus[31] == 1'b0, "R2 busy clears", {31'b0, ctrlStatus[31]}, 32'd0);
  endtask

  task automatic checkTx(input string req, input int n, input logic [7:0] e [0:15]);
    check(txCount == n, req, txCount, n);
    for (int i = 0; i < n && i < txCount; i++)
      check(txLog[i] == e[i], req, {24'b0, txLog[i]}, {24'b0, e[i]});
  endtask

  logic [7:0] ex [0:15];

  task automatic tReset();
    check(ctrlStatus == 0 && addrValue == 0 && dataValue == 0, "R1 reset regs", ctrlStatus | addrValue | dataValue, 0);
    check(spiCsN == 1'b1 && spiSclk == 1'b0, "R1 reset pins", {30'b0, spiCsN, spiSclk}, 32'd2);
  endtask

  task automatic tOpOnly();
    clearSlave();
    runFrame(mkCtrl(1, 0, 3'd0, 8'h06));
    ex[0] = 8'h06;
    checkTx("R4 code0", 1, ex);
    check(spiCsN == 1'b1, "R8 cs released", {31'b0, spiCsN}, 1);
    check(ctrlStatus == 32'h0000_0006, "R1 ctrl readback", ctrlStatus, 32'h0000_0006);
  endtask

  task automatic tOneData();
    clearSlave();
    writeReg(2'd2, 32'h1234_56AB);
    resp[1] = 8'h5A;
    runFrame(mkCtrl(1, 0, 3'd1, 8'h05));
    ex[0] = 8'h05; ex[1] = 8'hAB;
    checkTx("R4 code1", 2, ex);
    check(dataValue == 32'h1234_565A, "R6 one byte capture", dataValue, 32'h1234_565A);
    check(lastPeriod == CLK_DIV * 4, "R3 sclk period", lastPeriod, CLK_DIV * 4);
  endtask

  task automatic tAddrOnly();
    clearSlave();
    writeReg(2'd1, 32'h00A1_B2C3);
    runFrame(mkCtrl(1, 0, 3'd2, 8'hD8));
    ex[0] = 8'hD8; ex[1] = 8'hA1; ex[2] = 8'hB2; ex[3] = 8'hC3;
    checkTx("R5 address order", 4, ex);
  endtask

  task automatic tAddrOneData();
    clearSlave();
    writeReg(2'd1, 32'h000A_0B0C);
    writeReg(2'd2, 32'h0000_00C3);
    resp[4] = 8'h99;
    runFrame(mkCtrl(1, 0, 3'd3, 8'h02));
    ex[0] = 8'h02; ex[1] = 8'h0A; ex[2] = 8'h0B; ex[3] = 8'h0C; ex[4] = 8'hC3;
    checkTx("R4 code3", 5, ex);
    check(dataValue == 32'h0000_0099, "R6 code3 capture", dataValue, 32'h99);
  endtask

  task automatic tFourData();
    clearSlave();
    writeReg(2'd1, 32'h0012_3456);
    writeReg(2'd2, 32'h0403_0201);
    resp[4] = 8'h11; resp[5] = 8'h22; resp[6] = 8'h33; resp[7] = 8'h44;
    runFrame(mkCtrl(1, 0, 3'd4, 8'h03));
    ex[0] = 8'h03; ex[1] = 8'h12; ex[2] = 8'h34; ex[3] = 8'h56;
    ex[4] = 8'h01; ex[5] = 8'h02; ex[6] = 8'h03; ex[7] = 8'h04;
    checkTx("R6 code4 send lanes", 8, ex);
    check(dataValue == 32'h4433_2211, "R6 code4 capture lanes", dataValue, 32'h4433_2211);
  endtask

  task automatic tFourDummy();
    clearSlave();
    writeReg(2'd1, 32'h0000_0010);
    writeReg(2'd2, 32'h0);
    for (int i = 4; i < 8; i++) resp[i] = 8'hFF;
    resp[8] = 8'hA0; resp[9] = 8'hA1; resp[10] = 8'hA2; resp[11] = 8'hA3;
    runFrame(mkCtrl(1, 0, 3'd5, 8'h0B));
    for (int i = 0; i < 16; i++) ex[i] = 8'h00;
    ex[0] = 8'h0B; ex[3] = 8'h10;
    checkTx("R7 code5 dummies", 12, ex);
    check(dataValue == 32'hA3A2_A1A0, "R7 code5 capture", dataValue, 32'hA3A2_A1A0);
  endtask

  task automatic tOneDummy();
    clearSlave();
    writeReg(2'd1, 32'h00FE_DCBA);
    writeReg(2'd2, 32'h0);
    resp[4] = 8'hEE; resp[5] = 8'h05; resp[6] = 8'h06; resp[7] = 8'h07; resp[8] = 8'h08;
    runFrame(mkCtrl(1, 0, 3'd7, 8'h0B));
    for (int i = 0; i < 16; i++) ex[i] = 8'h00;
    ex[0] = 8'h0B; ex[1] = 8'hFE; ex[2] = 8'hDC; ex[3] = 8'hBA;
    checkTx("R7 code7 dummy", 9, ex);
    check(dataValue == 32'h0807_0605, "R7 code7 capture", dataValue, 32'h0807_0605);
  endtask

  task automatic tCode6();
    clearSlave();
    writeReg(2'd2, 32'h5555_5555);
    runFrame(mkCtrl(1, 0, 3'd6, 8'h9F));
    ex[0] = 8'h9F;
    checkTx("R4 code6 opcode only", 1, ex);
    check(dataValue == 32'h5555_5555, "R4 code6 data kept", dataValue, 32'h5555_5555);
  endtask

  task automatic tHoldStream();
    clearSlave();
    writeReg(2'd2, 32'h0000_0011);
    runFrame(mkCtrl(1, 1, 3'd1, 8'h02));
    check(spiCsN == 1'b0, "R8 cs held", {31'b0, spiCsN}, 0);
    runFrame(mkCtrl(1, 1, 3'd4, 8'h77));
    check(spiCsN == 1'b0, "R9 cs still held", {31'b0, spiCsN}, 0);
    runFrame(mkCtrl(1, 0, 3'd4, 8'h88));
    ex[0] = 8'h02; ex[1] = 8'h11; ex[2] = 8'h77; ex[3] = 8'h88;
    checkTx("R9 continuation bytes", 4, ex);
    check(spiCsN == 1'b1, "R9 last byte releases", {31'b0, spiCsN}, 1);
  endtask

  task automatic tRelease();
    clearSlave();
    runFrame(mkCtrl(1, 1, 3'd0, 8'h06));
    check(spiCsN == 1'b0, "R8 held again", {31'b0, spiCsN}, 0);
    writeReg(2'd0, 32'h0);
    @(negedge clk);
    check(spiCsN == 1'b1, "R10 release", {31'b0, spiCsN}, 1);
    check(txCount == 1 && ctrlStatus[31] == 1'b0, "R10 no frame", txCount, 1);
  endtask

  task automatic tBusyIgnore();
    clearSlave();
    writeReg(2'd1, 32'h0000_0100);
    writeReg(2'd2, 32'h0);
    resp[4] = 8'h21; resp[5] = 8'h43; resp[6] = 8'h65; resp[7] = 8'h87;
    writeReg(2'd0, mkCtrl(1, 0, 3'd4, 8'h03));
    writeReg(2'd0, mkCtrl(1, 1, 3'd0, 8'hAA));
    writeReg(2'd1, 32'h00FF_FFFF);
    writeReg(2'd2, 32'hDEAD_BEEF);
    waitIdle();
    for (int i = 0; i < 16; i++) ex[i] = 8'h00;
    ex[0] = 8'h03; ex[2] = 8'h01;
    checkTx("R11 frame unchanged", 8, ex);
    check(addrValue == 32'h0000_0100, "R11 addr kept", addrValue, 32'h100);
    check(ctrlStatus == 32'h0000_0403, "R11 ctrl kept", ctrlStatus, 32'h0000_0403);
    check(dataValue == 32'h8765_4321, "R11 data from device", dataValue, 32'h8765_4321);
    check(spiCsN == 1'b1, "R11 cs released", {31'b0, spiCsN}, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin resp[i] = 8'h00; txLog[i] = 8'h00; end
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tOpOnly();
    tOneData();
    tAddrOnly();
    tAddrOneData();
    tFourData();
    tFourDummy();
    tOneDummy();
    tCode6();
    tHoldStream();
    tRelease();
    tBusyIgnore();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule